// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Resolver

This block arbitrates among a row of interrupt sources that share one request line. Each source owns a cell with a request flip-flop. The cells are linked in series: an acknowledge enters the first cell and travels down the chain. Any cell with a pending request stops the acknowledge from going further. The cell nearest the head of the chain therefore wins. The winning cell raises its own vector enable, and its vector address appears on the data output.

All pending requests together drive one shared active-low interrupt line. The winning cell keeps its request for a fixed number of clock cycles after its vector first appears, which gives the processor time to capture the vector. The cell then drops the request, and the acknowledge moves on to the next pending cell. While the acknowledge is high, the set of cells taking part in arbitration is frozen. A request that arrives during that time is recorded, but it cannot take the vector away from the cell that is answering.

Top module: `irq_prio_chain`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every request flip-flop is clear, irq_n is 1, vec_en is all zero and vec_data is zero.
- R2: irq_n is 0 whenever at least one cell's request flip-flop is set, and 1 when none is set.
- R3: A cell whose priority-in is 0 drives its priority-out to 0 and its vector enable to 0, whatever the state of its request. With ack_in at 0, vec_en is zero and chain_out is 0.
- R4: A cell whose priority-in is 1 and whose request is not eligible passes the acknowledge on with priority-out 1 and vector enable 0. chain_out is 1 only if ack_in is 1 and no cell is eligible.
- R5: A cell whose priority-in is 1 and whose request is eligible drives priority-out 0 and vector enable 1. Bit i of vec_en belongs to cell i, and cell 0 has the highest priority. vec_en is therefore at most one-hot, and it selects the lowest-indexed eligible cell.
- R6: vec_data equals VBASE + i*VSTEP (truncated to VW bits) while bit i of vec_en is high, and is zero when vec_en is zero.
- R7: A high dev_req[i] sampled at a clock edge sets the request flip-flop of cell i. The request stays set after dev_req[i] falls, until that cell is served.
- R8: A cell's request flip-flop clears at the clock edge that ends the HOLD-th cycle, counted from the first cycle in which its vector enable is high. The count runs to the end even if ack_in drops earlier. If dev_req[i] is high at that clearing edge, the clear takes priority for that edge.
- R9: A request that becomes set while ack_in is high does not become eligible for arbitration until a clock edge at which ack_in is 0. It still pulls irq_n low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | NDEV | Per-device interrupt request, sampled at the clock edge |
| ack_in | input | 1 | Processor acknowledge, priority-in of cell 0 |
| irq_n | output | 1 | Shared interrupt request, active low |
| vec_en | output | NDEV | Per-cell vector enable, at most one-hot |
| vec_data | output | VW | Vector address of the enabled cell, or zero |
| chain_out | output | 1 | Priority-out of the last cell |

## Verification
The bench builds the block with NDEV=5, VW=8, HOLD=3, VBASE=0x40 and VSTEP=4. With five cells, a served cell can sit in the middle of the chain, with eligible cells both above and below it. The non-trivial hold of three cycles lets the acknowledge drop, and new requests arrive, while a cell's clear countdown is still running. Directed phases cover the clear-versus-set collision and requests raised during an acknowledge. A long random phase then compares all outputs with a behavioural model on every cycle.

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int NDEV  = 4,
  parameter int VW    = 8,
  parameter int HOLD  = 3,
  parameter int VBASE = 32,
  parameter int VSTEP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic            ack_in,
  output logic            irq_n,
  output logic [NDEV-1:0] vec_en,
  output logic [VW-1:0]   vec_data,
  output logic            chain_out
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  logic [NDEV-1:0] rf, elig, busy, clr, rf_nx;
  logic [NDEV:0]   pi;
  logic [CW-1:0]   cnt [NDEV];

  always_comb begin
    pi[0] = ack_in;
    for (int i = 0; i < NDEV; i++) begin
      vec_en[i] = pi[i] & elig[i];
      pi[i+1]   = pi[i] & ~elig[i];
      busy[i]   = vec_en[i] | (cnt[i] != '0);
      clr[i]    = busy[i] && (cnt[i] == CW'(HOLD - 1));
      rf_nx[i]  = ~clr[i] & (rf[i] | dev_req[i]);
    end
  end

  always_comb begin
    vec_data = '0;
    for (int i = 0; i < NDEV; i++)
      vec_data = vec_data | ({VW{vec_en[i]}} & VW'(VBASE + i * VSTEP));
  end

  assign chain_out = pi[NDEV];
  assign irq_n     = ~|rf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf   <= '0;
      elig <= '0;
      for (int i = 0; i < NDEV; i++) cnt[i] <= '0;
    end else begin
      rf   <= rf_nx;
      elig <= ack_in ? (elig & ~clr) : rf_nx;
      for (int i = 0; i < NDEV; i++)
        cnt[i] <= (busy[i] && !clr[i]) ? cnt[i] + CW'(1) : '0;
    end
  end

  a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_en));
  a_r3_no_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |-> (vec_en == '0 && !chain_out));
  a_r6_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en == '0) |-> (vec_data == '0));
  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && elig == '0) |-> chain_out);
  a_r7_req_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_req & ~busy) != '0) |=> !irq_n);
  a_r9_hold_selection: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && $past(ack_in) && $past(rst_n) && busy == '0 && $past(busy) == '0) |-> $stable(elig));
endmodule

// File: tb/irq_prio_chain_bench.sv
module irq_prio_chain_bench;
  localparam int NDEV = 5, VW = 8, HOLD = 3, VBASE = 64, VSTEP = 4;

  logic clk = 0, rst_n = 0, ack_in = 0;
  logic [NDEV-1:0] dev_req = '0;
  logic irq_n, chain_out;
  logic [NDEV-1:0] vec_en;
  logic [VW-1:0] vec_data;

  irq_prio_chain #(.NDEV(NDEV), .VW(VW), .HOLD(HOLD), .VBASE(VBASE), .VSTEP(VSTEP)) u_irq_prio_chain (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_in(ack_in),
    .irq_n(irq_n), .vec_en(vec_en), .vec_data(vec_data), .chain_out(chain_out));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  int m_req [NDEV];
  int m_ok  [NDEV];
  int m_tm  [NDEV];

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, tag, act, exp);
    end
  endtask

  function automatic int winner();
    if (!ack_in) return -1;
    for (int i = 0; i < NDEV; i++) if (m_ok[i] != 0) return i;
    return -1;
  endfunction

  task automatic compare_all();
    int w = winner();
    int any = 0;
    for (int i = 0; i < NDEV; i++) if (m_req[i] != 0) any = 1;
    check("R2 irq_n", irq_n, any ? 0 : 1);
    check("R5 R3 vec_en", vec_en, (w < 0) ? 0 : (1 << w));
    check("R6 vec_data", vec_data, (w < 0) ? 0 : ((VBASE + w * VSTEP) & 255));
    check("R4 chain_out", chain_out, (ack_in && w < 0) ? 1 : 0);
  endtask

  task automatic model_edge();
    int w = winner();
    for (int i = 0; i < NDEV; i++) begin
      if (!rst_n) begin
        m_req[i] = 0; m_ok[i] = 0; m_tm[i] = 0;
      end else begin
        int clear = 0;
        if (w == i || m_tm[i] != 0) begin
          if (m_tm[i] == HOLD - 1) begin clear = 1; m_tm[i] = 0; end
          else m_tm[i]++;
        end
        if (clear) m_req[i] = 0;
        else if (dev_req[i]) m_req[i] = 1;
        if (!ack_in) m_ok[i] = m_req[i];
        else if (clear) m_ok[i] = 0;
      end
    end
  endtask

  task automatic step(logic [NDEV-1:0] req, logic ack);
    @(negedge clk);
    compare_all();
    dev_req = req;
    ack_in = ack;
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NDEV; i++) begin m_req[i] = 0; m_ok[i] = 0; m_tm[i] = 0; end
    phase = "R1";
    rst_n = 0;
    repeat (3) step('0, 0);
    rst_n = 1;
    step('0, 0);
    step('0, 1);
    step('0, 0);

    phase = "R7";
    step(5'b00100, 0);
    repeat (4) step('0, 0);

    phase = "R5";
    step(5'b10010, 0);
    step('0, 0);
    repeat (12) step('0, 1);
    repeat (3) step('0, 0);

    phase = "R8";
    step(5'b01000, 0);
    step('0, 1);
    repeat (5) step('0, 0);
    step(5'b00001, 0);
    repeat (8) step(5'b00001, 1);
    repeat (4) step('0, 0);
    repeat (4) step('0, 1);
    step('0, 0);

    phase = "R9";
    step('0, 1);
    step(5'b00001, 1);
    repeat (3) step('0, 1);
    step('0, 0);
    repeat (4) step('0, 1);
    step(5'b10000, 0);
    step('0, 1);
    step(5'b00001, 1);
    repeat (8) step('0, 1);
    step('0, 0);

    phase = "R3 R5 R6";
    for (int c = 0; c < 2000; c++) begin
      logic [NDEV-1:0] r;
      r = '0;
      for (int i = 0; i < NDEV; i++) r[i] = ($urandom % 9) == 0;
      step(r, ($urandom % 3) != 0);
    end
    step('0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule